// File: doc/BRIEF.md
# Endpoint Byte Count Register Bank

This block holds one transfer byte count per USB endpoint and sits between a processor register port and the serial interface engine. Before an IN transfer, firmware stores the number of bytes the transmitter must send, and the engine reads that value on a dedicated output. After a SETUP or OUT transaction, the engine reports the number of data bytes it received. The block stores that number plus the two CRC bytes that trail every data packet.

Endpoints marked as control endpoints (endpoint 0 by default) protect a freshly received count. A hardware update sets a lock, and processor writes are then dropped. The first processor read of that endpoint's register releases the lock. Firmware therefore cannot overwrite the result of an incoming transaction before it has looked at it. Other endpoints never lock.

Top module: `ep_count_bank`

## Requirements
- R1: After reset every endpoint count reads 0 and no endpoint is locked, so the first processor write to any endpoint takes effect.
- R2: An engine update of kind OUT (`upd_kind`=2'b00) or SETUP (2'b01) loads the addressed endpoint with `upd_nbytes`+2. If `upd_nbytes` exceeds 8, the stored value is 10. It is visible from the cycle after the strobe.
- R3: A processor write stores `cpu_wdata[3:0]`. Any value above 8 is stored as 8.
- R4: On a control endpoint (index 0), an OUT or SETUP update sets a lock, and processor writes to that endpoint are ignored while it is set.
- R5: A processor read of a locked control endpoint clears its lock, and a later write takes effect again.
- R6: When a read of the control endpoint and an update to it fall in the same cycle, the update is stored and the endpoint stays locked.
- R7: Non-control endpoints never lock: a processor write after an engine update takes effect.
- R8: Bits [7:4] of `cpu_rdata` read as 0. Bits [7:4] of `cpu_wdata` have no effect on the stored count.
- R9: An engine update of kind IN (2'b10) or the unused kind 2'b11 changes no count and no lock.
- R10: When a processor write and an engine update hit the same endpoint in the same cycle, the engine value is stored.
- R11: `tx_count` shows the count of endpoint `tx_ep` in the same cycle, and `cpu_rdata` shows the count of endpoint `cpu_sel` in the same cycle.
- R12: An update or write addressed to one endpoint leaves the counts and locks of all other endpoints unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_sel | input | 2 | Endpoint addressed by the processor port |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rd | input | 1 | Processor read strobe (releases a control endpoint lock) |
| cpu_wdata | input | 8 | Processor write data, count in bits [3:0] |
| cpu_rdata | output | 8 | Count of endpoint `cpu_sel`, zero-extended |
| upd_valid | input | 1 | Engine update strobe |
| upd_ep | input | 2 | Endpoint of the engine update |
| upd_kind | input | 2 | Transaction kind: 00 OUT, 01 SETUP, 10 IN, 11 unused |
| upd_nbytes | input | 4 | Data bytes received, CRC excluded |
| tx_ep | input | 2 | Endpoint the transmitter is serving |
| tx_count | output | 4 | Count of endpoint `tx_ep` |

## Verification
The bench builds the block with its default parameters: four endpoints, a 4-bit count, an IN limit of 8 and endpoint 0 as the only control endpoint. With these values one endpoint carries the lock, which lets the bench check lock-on-update, unlock-on-read and the same-cycle read/update collision. The remaining three endpoints show that non-control endpoints never lock. A 4-bit `upd_nbytes` can exceed 8, so both the IN saturation at 8 and the received saturation at 10 can be reached from the ports.

// File: rtl/ep_cnt_pkg.sv
package ep_cnt_pkg;

  typedef enum logic [1:0] {
    XFER_OUT   = 2'b00,
    XFER_SETUP = 2'b01,
    XFER_IN    = 2'b10,
    XFER_RSVD  = 2'b11
  } xfer_kind_e;

  // Receive kinds are the only ones that let the engine write a count.
  function automatic logic is_rx_kind(input logic [1:0] kind);
    return (kind == XFER_OUT) || (kind == XFER_SETUP);
  endfunction

endpackage

// File: rtl/ep_cnt_rst_sync.sv
module ep_cnt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/ep_cnt_front.sv
module ep_cnt_front
  import ep_cnt_pkg::*;
#(
  parameter int N_EP      = 4,
  parameter int EP_W      = 2,
  parameter int CNT_W     = 4,
  parameter int DATA_W    = 8,
  parameter int MAX_IN    = 8,
  parameter int CRC_BYTES = 2
) (
  input  logic [EP_W-1:0]   cpu_sel,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              upd_valid,
  input  logic [EP_W-1:0]   upd_ep,
  input  logic [1:0]        upd_kind,
  input  logic [CNT_W-1:0]  upd_nbytes,
  output logic [N_EP-1:0]   wr_hit,
  output logic [N_EP-1:0]   rd_hit,
  output logic [N_EP-1:0]   hw_hit,
  output logic [CNT_W-1:0]  wr_cnt,
  output logic [CNT_W-1:0]  hw_cnt
);

  localparam int MAX_RX = MAX_IN + CRC_BYTES;

  logic [CNT_W:0]   rx_sum;
  logic [CNT_W-1:0] wr_field;
  logic             rx_ok;

  assign wr_field = cpu_wdata[CNT_W-1:0];
  assign rx_ok    = upd_valid && is_rx_kind(upd_kind);

  always_comb begin
    if (wr_field > CNT_W'(MAX_IN)) wr_cnt = CNT_W'(MAX_IN);
    else                           wr_cnt = wr_field;
  end

  always_comb begin
    rx_sum = {1'b0, upd_nbytes} + (CNT_W+1)'(CRC_BYTES);
    if (rx_sum > (CNT_W+1)'(MAX_RX)) hw_cnt = CNT_W'(MAX_RX);
    else                             hw_cnt = rx_sum[CNT_W-1:0];
  end

  for (genvar e = 0; e < N_EP; e++) begin : g_dec
    assign wr_hit[e] = cpu_wr && (cpu_sel == EP_W'(e));
    assign rd_hit[e] = cpu_rd && (cpu_sel == EP_W'(e));
    assign hw_hit[e] = rx_ok  && (upd_ep  == EP_W'(e));
  end

endmodule

// File: rtl/ep_cnt_slot.sv
module ep_cnt_slot #(
  parameter int CNT_W    = 4,
  parameter int MAX_IN   = 8,
  parameter int MAX_RX   = 10,
  parameter bit LOCKABLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_hit,
  input  logic [CNT_W-1:0] hw_cnt,
  input  logic             wr_hit,
  input  logic             rd_hit,
  input  logic [CNT_W-1:0] wr_cnt,
  output logic [CNT_W-1:0] cnt_q
);

  logic             lock_q;
  logic             lock_d;
  logic             lock_en;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Count: engine update has priority over a processor write.
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (hw_hit) begin
      cnt_en = 1'b1;
      cnt_d  = hw_cnt;
    end else if (wr_hit && !lock_q) begin
      cnt_en = 1'b1;
      cnt_d  = wr_cnt;
    end
  end

  // Lock: set by a receive update, cleared by a read; update wins a tie.
  always_comb begin
    lock_en = 1'b0;
    lock_d  = lock_q;
    if (LOCKABLE && hw_hit) begin
      lock_en = 1'b1;
      lock_d  = 1'b1;
    end else if (rd_hit) begin
      lock_en = 1'b1;
      lock_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= 1'b0;
    else if (lock_en) lock_q <= lock_d;
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_RX));

  p_in_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !hw_hit && !lock_q) |=> (cnt_q <= CNT_W'(MAX_IN)));

  p_hw_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_hit && wr_hit) |=> (cnt_q == $past(hw_cnt)));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_hit && !wr_hit) |=> $stable(cnt_q));

  if (LOCKABLE) begin : g_lock_chk
    p_locked_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && wr_hit && !hw_hit) |=> $stable(cnt_q));
    p_upd_locks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hw_hit |=> lock_q);
    p_rd_unlocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && rd_hit && !hw_hit) |=> !lock_q);
  end else begin : g_nolock_chk
    p_never_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_q);
  end

endmodule

// File: rtl/ep_cnt_mux.sv
module ep_cnt_mux #(
  parameter int N_EP   = 4,
  parameter int EP_W   = 2,
  parameter int CNT_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic [N_EP-1:0][CNT_W-1:0] cnt_all,
  input  logic [EP_W-1:0]            cpu_sel,
  input  logic [EP_W-1:0]            tx_ep,
  output logic [DATA_W-1:0]          cpu_rdata,
  output logic [CNT_W-1:0]           tx_count
);

  localparam int PAD_W = DATA_W - CNT_W;

  logic [CNT_W-1:0] rd_cnt;

  always_comb begin
    rd_cnt   = '0;
    tx_count = '0;
    for (int e = 0; e < N_EP; e++) begin
      if (cpu_sel == EP_W'(e)) rd_cnt   = cnt_all[e];
      if (tx_ep   == EP_W'(e)) tx_count = cnt_all[e];
    end
  end

  assign cpu_rdata = {{PAD_W{1'b0}}, rd_cnt};

endmodule

// File: rtl/ep_count_bank.sv
module ep_count_bank #(
  parameter int          N_EP      = 4,
  parameter int          CNT_W     = 4,
  parameter int          DATA_W    = 8,
  parameter int          MAX_IN    = 8,
  parameter int          CRC_BYTES = 2,
  parameter logic [N_EP-1:0] CTRL_MASK = N_EP'(1),
  localparam int         EP_W      = (N_EP > 1) ? $clog2(N_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EP_W-1:0]   cpu_sel,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              upd_valid,
  input  logic [EP_W-1:0]   upd_ep,
  input  logic [1:0]        upd_kind,
  input  logic [CNT_W-1:0]  upd_nbytes,
  input  logic [EP_W-1:0]   tx_ep,
  output logic [CNT_W-1:0]  tx_count
);

  localparam int MAX_RX = MAX_IN + CRC_BYTES;

  logic                       rst_n_sync;
  logic [N_EP-1:0]            wr_hit;
  logic [N_EP-1:0]            rd_hit;
  logic [N_EP-1:0]            hw_hit;
  logic [CNT_W-1:0]           wr_cnt;
  logic [CNT_W-1:0]           hw_cnt;
  logic [N_EP-1:0][CNT_W-1:0] cnt_all;

  ep_cnt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  ep_cnt_front #(
    .N_EP(N_EP), .EP_W(EP_W), .CNT_W(CNT_W), .DATA_W(DATA_W),
    .MAX_IN(MAX_IN), .CRC_BYTES(CRC_BYTES)
  ) u_front (
    .cpu_sel    (cpu_sel),
    .cpu_wr     (cpu_wr),
    .cpu_rd     (cpu_rd),
    .cpu_wdata  (cpu_wdata),
    .upd_valid  (upd_valid),
    .upd_ep     (upd_ep),
    .upd_kind   (upd_kind),
    .upd_nbytes (upd_nbytes),
    .wr_hit     (wr_hit),
    .rd_hit     (rd_hit),
    .hw_hit     (hw_hit),
    .wr_cnt     (wr_cnt),
    .hw_cnt     (hw_cnt)
  );

  for (genvar e = 0; e < N_EP; e++) begin : g_slot
    ep_cnt_slot #(
      .CNT_W(CNT_W), .MAX_IN(MAX_IN), .MAX_RX(MAX_RX),
      .LOCKABLE(CTRL_MASK[e])
    ) u_slot (
      .clk    (clk),
      .rst_n  (rst_n_sync),
      .hw_hit (hw_hit[e]),
      .hw_cnt (hw_cnt),
      .wr_hit (wr_hit[e]),
      .rd_hit (rd_hit[e]),
      .wr_cnt (wr_cnt),
      .cnt_q  (cnt_all[e])
    );
  end

  ep_cnt_mux #(
    .N_EP(N_EP), .EP_W(EP_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) u_mux (
    .cnt_all   (cnt_all),
    .cpu_sel   (cpu_sel),
    .tx_ep     (tx_ep),
    .cpu_rdata (cpu_rdata),
    .tx_count  (tx_count)
  );

  // R9: non-receive kinds must leave every count untouched.
  p_in_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (upd_valid && !ep_cnt_pkg::is_rx_kind(upd_kind) && !cpu_wr) |=> $stable(cnt_all));

  p_rx_load_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (upd_valid && ep_cnt_pkg::is_rx_kind(upd_kind)) |=>
      (cnt_all[$past(upd_ep)] >= CNT_W'(CRC_BYTES)));

endmodule

// File: tb/ep_count_bank_test.sv
module ep_count_bank_test;

  localparam int CLK_P  = 10;
  localparam int N_EP   = 4;
  localparam int MAX_IN = 8;
  localparam int MAX_RX = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cpu_sel = '0;
  logic       cpu_wr = 1'b0;
  logic       cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       upd_valid = 1'b0;
  logic [1:0] upd_ep = '0;
  logic [1:0] upd_kind = '0;
  logic [3:0] upd_nbytes = '0;
  logic [1:0] tx_ep = '0;
  logic [3:0] tx_count;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  int m_cnt  [N_EP];
  bit m_lock [N_EP];

  ep_count_bank uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .upd_valid(upd_valid), .upd_ep(upd_ep), .upd_kind(upd_kind),
    .upd_nbytes(upd_nbytes), .tx_ep(tx_ep), .tx_count(tx_count)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference update for one clock, from the requirement text.
  task automatic model_clock(input bit wr, input bit rd, input int sel, input int wd,
                             input bit uv, input int ue, input int uk, input int nb);
    for (int e = 0; e < N_EP; e++) begin
      bit hit;
      int w;
      hit = uv && (ue == e) && (uk == 0 || uk == 1);
      w   = wd % 16;
      if (hit) m_cnt[e] = (nb + 2 > MAX_RX) ? MAX_RX : nb + 2;
      else if (wr && sel == e && !m_lock[e]) m_cnt[e] = (w > MAX_IN) ? MAX_IN : w;
      if (hit && e == 0) m_lock[e] = 1'b1;
      else if (rd && sel == e) m_lock[e] = 1'b0;
    end
  endtask

  task automatic step(input string tag, input bit wr, input bit rd, input int sel,
                      input int wd, input bit uv, input int ue, input int uk,
                      input int nb, input int txe);
    cpu_wr = wr; cpu_rd = rd; cpu_sel = 2'(sel); cpu_wdata = 8'(wd);
    upd_valid = uv; upd_ep = 2'(ue); upd_kind = 2'(uk); upd_nbytes = 4'(nb);
    tx_ep = 2'(txe);
    #(CLK_P/4);
    check(tag, "cpu_rdata", int'(cpu_rdata), m_cnt[sel]);
    check(tag, "tx_count",  int'(tx_count),  m_cnt[txe]);
    @(posedge clk);
    model_clock(wr, rd, sel, wd, uv, ue, uk, nb);
    #1;
  endtask

  task automatic idle(input string tag, input int sel, input int txe);
    step(tag, 0, 0, sel, 0, 0, 0, 0, 0, txe);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < N_EP; e++) begin m_cnt[e] = 0; m_lock[e] = 1'b0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values, all slots
    for (int e = 0; e < N_EP; e++) idle("R1", e, e);
    // R1: first write to the control endpoint lands
    step("R1", 1, 0, 0, 4, 0, 0, 0, 0, 0);
    idle("R1", 0, 0);
    // R3: write and saturation
    step("R3", 1, 0, 1, 5, 0, 0, 0, 0, 1);
    idle("R3", 1, 1);
    step("R3", 1, 0, 1, 15, 0, 0, 0, 0, 1);
    idle("R3", 1, 1);
    // R8: upper write bits ignored, read pad zero
    step("R8", 1, 0, 1, 8'hF3, 0, 0, 0, 0, 1);
    idle("R8", 1, 1);
    check("R8", "rdata upper", int'(cpu_rdata[7:4]), 0);
    // R2: received counts
    step("R2", 0, 0, 2, 0, 1, 2, 0, 6, 2);
    idle("R2", 2, 2);
    step("R2", 0, 0, 2, 0, 1, 2, 1, 8, 2);
    idle("R2", 2, 2);
    step("R2", 0, 0, 2, 0, 1, 2, 0, 0, 2);
    idle("R2", 2, 2);
    step("R2", 0, 0, 2, 0, 1, 2, 0, 12, 2);
    idle("R2", 2, 2);
    // R4: lock on control endpoint
    step("R4", 0, 0, 0, 0, 1, 0, 1, 8, 0);
    step("R4", 1, 0, 0, 3, 0, 0, 0, 0, 0);
    idle("R4", 0, 0);
    check("R4", "locked count", int'(tx_count), 10);
    // R6: read and update together keeps the lock
    step("R6", 0, 1, 0, 0, 1, 0, 0, 1, 0);
    step("R6", 1, 0, 0, 5, 0, 0, 0, 0, 0);
    idle("R6", 0, 0);
    check("R6", "still locked", int'(cpu_rdata), 3);
    // R5: read unlocks
    step("R5", 0, 1, 0, 0, 0, 0, 0, 0, 0);
    step("R5", 1, 0, 0, 5, 0, 0, 0, 0, 0);
    idle("R5", 0, 0);
    check("R5", "unlocked write", int'(cpu_rdata), 5);
    // R7: other endpoints never lock
    step("R7", 0, 0, 3, 0, 1, 3, 0, 4, 3);
    step("R7", 1, 0, 3, 7, 0, 0, 0, 0, 3);
    idle("R7", 3, 3);
    check("R7", "write after update", int'(tx_count), 7);
    // R9: IN and unused kinds ignored
    step("R9", 0, 0, 1, 0, 1, 1, 2, 3, 1);
    idle("R9", 1, 1);
    step("R9", 0, 0, 0, 0, 1, 0, 3, 3, 0);
    step("R9", 1, 0, 0, 6, 0, 0, 0, 0, 0);
    idle("R9", 0, 0);
    check("R9", "no lock from IN", int'(cpu_rdata), 6);
    // R10: update beats write
    step("R10", 1, 0, 2, 4, 1, 2, 0, 1, 2);
    idle("R10", 2, 2);
    check("R10", "engine wins", int'(tx_count), 3);
    // R11: transmit and read sweep with different selectors
    for (int e = 0; e < N_EP; e++) idle("R11", e, (e + 1) % N_EP);
    // R12: mixed traffic against the model
    for (int i = 0; i < 300; i++) begin
      int r;
      r = int'($urandom);
      step("R12", r[0], r[1], (r >> 2) & 3, (r >> 4) & 255, r[12] & r[13],
           (r >> 14) & 3, (r >> 16) & 3, (r >> 18) & 15, (r >> 22) & 3);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule